// File: doc/BRIEF.md
# Oversampled Serial Receiver with Held Character Buffer

This block turns an asynchronous serial line into characters. A free-running tick at sixteen times the bit rate paces it. Each frame has one low start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. Four static format inputs select the format, and they must agree with the sender. The line input passes through a synchronizer before use.

A finished character moves out of the shift register into a holding register. That register keeps it while the next frame is shifted in. At the midpoint of the first stop bit, several things change on the same clock edge: the full flag rises, the overrun, parity and framing flags take their new values, and an interrupt pulse is raised. The consumer pulses a read strobe to take the character and drop the full flag. Error flags stay set until a separate clear strobe.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After synchronous reset, `rx_data` is 0 and `rx_full`, `err_overrun`, `err_parity`, `err_frame` and `rx_irq` are all 0.
- R2: A low level seen on a tick while idle starts a frame only if the line is still low on the 8th tick after that one. Otherwise the receiver goes back to idle and reports nothing.
- R3: Each bit lasts 16 ticks and is sampled on its 8th tick. Data bits arrive least significant bit first. With `fmt_len8`=1 all 8 bits form `rx_data`.
- R4: With `fmt_len8`=0, seven data bits are received and appear in `rx_data[6:0]`, with `rx_data[7]`=0.
- R5: With `fmt_par_en`=1, one parity bit follows the data. `fmt_par_odd`=0 selects even parity, where data ones plus the parity bit give an even count, and 1 selects odd. A mismatch sets `err_parity`.
- R6: A first stop bit sampled low sets `err_frame`.
- R7: `rx_full` and all three error flags change on the clock edge of the first stop bit's mid-bit sample tick.
- R8: A finished character is loaded into `rx_data` and sets `rx_full` if the buffer is empty or is read on the same cycle. The held character stays unchanged while the next frame is received. `rd_strobe` clears `rx_full`.
- R9: If a character finishes while `rx_full`=1 and no read strobe is present, `err_overrun` is set and `rx_data` keeps the old character.
- R10: `rx_irq` is a one-cycle pulse on the edge where `rx_full` is set by a load. No pulse is raised on an overrun.
- R11: Error flags are sticky. `err_clr` clears all three without touching `rx_data` or `rx_full`. A new error on the same cycle wins over the clear.
- R12: With `fmt_stop2`=1, frames with two stop bits are received. Completion still happens at the first stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| fmt_len8 | input | 1 | 1: eight data bits, 0: seven |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even |
| fmt_stop2 | input | 1 | Two stop bits |
| rd_strobe | input | 1 | Takes the held character, clears full flag |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | DATA_W | Held character |
| rx_full | output | 1 | Holding register contains an unread character |
| err_overrun | output | 1 | Character lost because the buffer was full |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | First stop bit was low |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The frames sent include 8-bit with no parity, even and odd parity with correct and deliberately flipped parity bits, 7-bit with two stop bits, and a low stop bit. Together they separate data alignment, parity polarity and framing detection. A short low pulse of five ticks tests the start-bit check. Back-to-back frames with no read, and a read strobe issued in the middle of the next frame, show the difference between overrun and normal buffering. A behavioural model predicts every output on every clock, which pins the update to the first stop bit's sample edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } rx_fmt_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  rx_fmt_t           fmt,
  output logic              done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_pe,
  output logic              char_fe
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic [DATA_W-1:0]  shreg;
  logic               par_acc;
  logic               par_bit;
  logic               at_mid;
  logic               at_last;
  logic [IDX_W-1:0]   last_idx;

  assign at_mid   = (cnt == MID);
  assign at_last  = (cnt == LAST);
  assign last_idx = fmt.len8 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      par_bit <= 1'b0;
    end else if (tick) begin
      if (state == RX_IDLE) begin
        if (!rxd_s) begin
          state <= RX_START;
          cnt   <= CNT_W'(1);
        end
      end else begin
        cnt <= at_last ? '0 : cnt + 1'b1;
        case (state)
          RX_START: begin
            if (at_mid && rxd_s) begin
              state <= RX_IDLE;
            end else if (at_last) begin
              state   <= RX_DATA;
              bit_idx <= '0;
              par_acc <= 1'b0;
            end
          end
          RX_DATA: begin
            if (at_mid) begin
              shreg   <= {rxd_s, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ rxd_s;
            end
            if (at_last) begin
              if (bit_idx == last_idx) state <= fmt.par_en ? RX_PAR : RX_STOP1;
              else                     bit_idx <= bit_idx + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_mid)  par_bit <= rxd_s;
            if (at_last) state   <= RX_STOP1;
          end
          RX_STOP1: begin
            if (at_mid) state <= fmt.stop2 ? RX_STOP2 : RX_IDLE;
          end
          RX_STOP2: begin
            if (at_mid) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign done      = tick && (state == RX_STOP1) && at_mid;
  assign char_data = fmt.len8 ? shreg : {1'b0, shreg[DATA_W-1:1]};
  assign char_pe   = fmt.par_en && ((par_acc ^ par_bit) != fmt.par_odd);
  assign char_fe   = !rxd_s;

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_pe,
  input  logic              char_fe,
  input  logic              rd,
  input  logic              clr,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ovr_q,
  output logic              pe_q,
  output logic              fe_q,
  output logic              irq_q
);

  logic lost;
  assign lost = done && full_q && !rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done && !lost) begin
        data_q <= char_data;
        full_q <= 1'b1;
        irq_q  <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
      ovr_q <= (ovr_q && !clr) || lost;
      pe_q  <= (pe_q  && !clr) || (done && char_pe);
      fe_q  <= (fe_q  && !clr) || (done && char_fe);
    end
  end

endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              fmt_len8,
  input  logic              fmt_par_en,
  input  logic              fmt_par_odd,
  input  logic              fmt_stop2,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_overrun,
  output logic              err_parity,
  output logic              err_frame,
  output logic              rx_irq
);

  rx_fmt_t           fmt;
  logic              rxd_s;
  logic              frame_done;
  logic [DATA_W-1:0] char_data;
  logic              char_pe;
  logic              char_fe;

  assign fmt = '{len8: fmt_len8, par_en: fmt_par_en, par_odd: fmt_par_odd, stop2: fmt_stop2};

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .rxd_s    (rxd_s),
    .fmt      (fmt),
    .done     (frame_done),
    .char_data(char_data),
    .char_pe  (char_pe),
    .char_fe  (char_fe)
  );

  rx_hold_buffer #(.DATA_W(DATA_W)) buf_i (
    .clk      (clk),
    .rst      (rst),
    .done     (frame_done),
    .char_data(char_data),
    .char_pe  (char_pe),
    .char_fe  (char_fe),
    .rd       (rd_strobe),
    .clr      (err_clr),
    .data_q   (rx_data),
    .full_q   (rx_full),
    .ovr_q    (err_overrun),
    .pe_q     (err_parity),
    .fe_q     (err_frame),
    .irq_q    (rx_irq)
  );

endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_done,
  input logic              rd_strobe,
  input logic              err_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              err_overrun,
  input logic              err_parity,
  input logic              err_frame,
  input logic              rx_irq
);

  assert_full_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(frame_done));

  assert_frame_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_frame) |-> $past(frame_done));

  assert_load_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !rx_full) |=> (rx_full && rx_irq));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (!rx_full || rx_irq));

  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_full && !rd_strobe) |=> (err_overrun && $stable(rx_data) && !rx_irq));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  assert_irq_full_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !frame_done) |=> (!err_overrun && !err_parity && !err_frame));

endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .frame_done (frame_done),
  .rd_strobe  (rd_strobe),
  .err_clr    (err_clr),
  .rx_data    (rx_data),
  .rx_full    (rx_full),
  .err_overrun(err_overrun),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .rx_irq     (rx_irq)
);

// File: tb/uart_rx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_rx_dbuf_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       len8 = 1'b1, pen = 1'b0, podd = 1'b0, stop2 = 1'b0;
  logic       rd = 1'b0, clr = 1'b0;
  logic [1:0] cyc = 2'd0;
  logic       tick;
  logic [7:0] rx_data;
  logic       rx_full, err_overrun, err_parity, err_frame, rx_irq;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 2'd1;
  assign tick = (cyc == 2'd3);

  uart_rx_dbuf dut_i (
    .clk(clk), .rst(rst), .baud_tick(tick), .rxd(rxd),
    .fmt_len8(len8), .fmt_par_en(pen), .fmt_par_odd(podd), .fmt_stop2(stop2),
    .rd_strobe(rd), .err_clr(clr),
    .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
    .err_parity(err_parity), .err_frame(err_frame), .rx_irq(rx_irq)
  );

  // behavioural reference: completion requests come from the frame driver
  logic       req = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       req_pe = 1'b0, req_fe = 1'b0;
  logic [7:0] m_data;
  logic       m_full, m_ovr, m_pe, m_fe, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_data = 8'h00; m_full = 0; m_ovr = 0; m_pe = 0; m_fe = 0; m_irq = 0;
    end else begin
      automatic bit was_full = m_full;
      automatic bit lost = req && was_full && !rd;
      m_irq = 0;
      if (req && !lost) begin
        m_data = req_data; m_full = 1; m_irq = 1;
      end else if (rd) begin
        m_full = 0;
      end
      m_ovr = (m_ovr && !clr) || lost;
      m_pe  = (m_pe && !clr) || (req && req_pe);
      m_fe  = (m_fe && !clr) || (req && req_fe);
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk(rx_data, m_data, "R3 R4 per-cycle data");
      chk({7'd0, rx_full}, {7'd0, m_full}, "R8 per-cycle full");
      chk({7'd0, err_overrun}, {7'd0, m_ovr}, "R9 per-cycle overrun");
      chk({7'd0, err_parity}, {7'd0, m_pe}, "R5 per-cycle parity");
      chk({7'd0, err_frame}, {7'd0, m_fe}, "R6 per-cycle framing");
      chk({7'd0, rx_irq}, {7'd0, m_irq}, "R10 per-cycle irq");
    end
  end

  task automatic wait_phase(input logic [1:0] p);
    do @(negedge clk); while (cyc != p);
  endtask

  task automatic idle_groups(input int n);
    repeat (n) wait_phase(2'd0);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_ok,
                            input bit exp_irq);
    int nd, np, ns, nb, s;
    logic [12:0] fb;
    logic [7:0] dm;
    bit par, skip;
    nd = len8 ? 8 : 7;
    np = pen ? 1 : 0;
    ns = stop2 ? 2 : 1;
    nb = 1 + nd + np + ns;
    dm = len8 ? d : (d & 8'h7F);
    par = ($countones(dm) % 2) == 1;
    if (podd) par = !par;
    if (bad_par) par = !par;
    fb = '1;
    fb[0] = 1'b0;
    for (int i = 0; i < nd; i++) fb[1+i] = dm[i];
    if (pen) fb[1+nd] = par;
    fb[1+nd+np] = stop_ok;
    s = 16 * (1 + nd + np) + 8;
    skip = 0;
    for (int g = 0; g < 16 * nb; g++) begin
      if (!skip) wait_phase(2'd0);
      skip = 0;
      rxd = fb[g / 16];
      if (g == s) begin
        wait_phase(2'd3);
        req = 1'b1; req_data = dm; req_pe = pen && bad_par; req_fe = !stop_ok;
        @(negedge clk);
        req = 1'b0;
        chk({7'd0, rx_irq}, {7'd0, exp_irq}, "R7 update at first stop sample");
        skip = 1;
      end
    end
    wait_phase(2'd0);
    rxd = 1'b1;
    idle_groups(20);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_data, 8'h00, "R1 reset data");
    chk({3'd0, rx_full, err_overrun, err_parity, err_frame, rx_irq}, 8'h00, "R1 reset flags");
    idle_groups(4);

    // 8N1
    send_frame(8'hA5, 0, 1, 1);
    chk(rx_data, 8'hA5, "R3 8-bit LSB first");
    chk({7'd0, rx_full}, 8'd1, "R8 full after frame");
    pulse_rd();
    @(negedge clk);
    chk({7'd0, rx_full}, 8'd0, "R8 read clears full");

    // 8E1 good, 8O1 bad
    pen = 1; podd = 0;
    send_frame(8'h3C, 0, 1, 1);
    chk({7'd0, err_parity}, 8'd0, "R5 even parity ok");
    pulse_rd();
    podd = 1;
    send_frame(8'h81, 1, 1, 1);
    chk({7'd0, err_parity}, 8'd1, "R5 odd parity mismatch");
    chk(rx_data, 8'h81, "R5 data with parity");
    pulse_clr();
    @(negedge clk);
    chk({7'd0, err_parity}, 8'd0, "R11 clear parity");
    chk(rx_data, 8'h81, "R11 clear keeps data");
    chk({7'd0, rx_full}, 8'd1, "R11 clear keeps full");
    pulse_rd();

    // 7E2
    len8 = 0; podd = 0; stop2 = 1;
    send_frame(8'hD3, 0, 1, 1);
    chk(rx_data, 8'h53, "R4 seven-bit data");
    chk({7'd0, err_parity}, 8'd0, "R12 two-stop frame parity ok");
    pulse_rd();
    send_frame(8'h2A, 0, 1, 1);
    chk(rx_data, 8'h2A, "R12 second two-stop frame");
    pulse_rd();

    // framing error, 8N1
    len8 = 1; pen = 0; stop2 = 0;
    send_frame(8'h5A, 0, 0, 1);
    chk({7'd0, err_frame}, 8'd1, "R6 low stop bit");
    pulse_rd();
    pulse_clr();
    @(negedge clk);
    chk({7'd0, err_frame}, 8'd0, "R11 clear framing");

    // overrun
    send_frame(8'h11, 0, 1, 1);
    send_frame(8'h22, 0, 1, 0);
    chk({7'd0, err_overrun}, 8'd1, "R9 overrun set");
    chk(rx_data, 8'h11, "R9 old character kept");
    pulse_clr();
    @(negedge clk);
    chk({7'd0, err_overrun}, 8'd0, "R11 clear overrun");
    pulse_rd();

    // read during next frame
    send_frame(8'h55, 0, 1, 1);
    fork
      send_frame(8'h66, 0, 1, 1);
      begin
        repeat (300) @(negedge clk);
        chk(rx_data, 8'h55, "R8 held during next frame");
        pulse_rd();
      end
    join
    chk(rx_data, 8'h66, "R8 next character loaded");
    chk({7'd0, err_overrun}, 8'd0, "R8 no overrun after read");
    pulse_rd();

    // short low pulse rejected
    wait_phase(2'd0);
    rxd = 1'b0;
    idle_groups(5);
    rxd = 1'b1;
    idle_groups(30);
    chk({7'd0, rx_full}, 8'd0, "R2 glitch gives no character");
    chk({5'd0, err_overrun, err_parity, err_frame}, 8'd0, "R2 glitch gives no error");
    send_frame(8'hC7, 0, 1, 1);
    chk(rx_data, 8'hC7, "R2 frame after glitch");

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule